// File: doc/BRIEF.md
# Profile-Based Amplifier Gain Serial Writer

This block keeps one 8-bit gain value for each of four transmit profiles and keeps an external variable-gain amplifier programmed with the gain of whichever profile is active. The amplifier is reached over a 3-wire serial port made of an active-low chip select, a serial clock and a data line. The host writes the gain values through a simple write strobe with address and data.

The active profile comes from two asynchronous profile pins, which are first synchronized, combined by bitwise OR with two profile-select bits held in the control register. No host command starts a transfer. The block compares the effective gain with a shadow copy of the last value it sent. When they differ, it waits until the new value has been steady for a settle window and then sends one 8-bit frame.

A frame that has begun always runs to its end. A gain that moves while a frame is on the wire is picked up afterwards, through a fresh settle window. Hardware reset forces a zero frame. A software reset clears the gains and the select bits, and it sends a zero frame only when the amplifier was holding a nonzero gain.

Top module: `gain_serial_writer`

## Requirements
- R1: A write with `wr_addr` = 1 + p (p = 0..3) stores `wr_data` as the gain of profile p. Addresses 5 to 7 are ignored.
- R2: The active profile index is `prof_pin` OR the select bits, where `prof_pin[0]` pairs with select bit 0 and `prof_pin[1]` with select bit 1. The pins pass through two synchronizing flops. A write to address 0 with bit 5 clear loads the select bits from `wr_data[1:0]`. Every frame carries the gain of the active profile.
- R3: Out of hardware reset, `amp_cs_n` is 1 and `amp_sclk` is 0, all gains are 0, and one frame of value 0x00 is sent.
- R4: A write to address 0 with `wr_data[5]` = 1 is a software reset. It clears all four gains and forces the select bits to 0, whatever the other data bits are. It sends a 0x00 frame only if the last value sent was nonzero.
- R5: A change of the active profile that leaves the effective gain equal to the last value sent produces no frame.
- R6: A write that changes the active profile's gain produces a frame with the new value. A write to an inactive profile produces no frame. A write of the value already sent produces no frame.
- R7: `amp_cs_n` falls between 48 and 64 clock cycles after the effective gain takes its new value. Any change during that wait restarts the wait, so only the final value is sent.
- R8: A frame holds `amp_cs_n` low for exactly 64 cycles. Within it, `amp_sclk` is the clock divided by 8 (4 cycles low, then 4 high) and gives 8 rising edges. Data goes out MSB first and changes only while `amp_sclk` is low. `amp_sclk` is 0 whenever `amp_cs_n` is 1.
- R9: A frame in progress completes even if the gain changes during it. The newest value is then sent in a following frame.
- R10: `amp_cs_n` stays high for at least 16 cycles between frames. A transfer finishes within 200 cycles of its trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1..4 profile gains) |
| wr_data | input | 8 | Register write data |
| prof_pin | input | 2 | Asynchronous profile select pins |
| amp_cs_n | output | 1 | Amplifier chip select, active low |
| amp_sclk | output | 1 | Amplifier serial clock |
| amp_sdata | output | 1 | Amplifier serial data, MSB first |

## Verification
After a register write, chip select falls 57 cycles after the capturing edge. After a pin change, it falls 59 cycles after the last edge before the pins move, because the synchronizer adds two flops. After reset, it falls 57 cycles after release. The bench records the cycle of each falling edge and checks it against the required 48 to 64 cycle window, rather than an exact count. A monitor samples data on the falling clock edge, collects bits on each rising serial clock, and checks the frame value, the bit count and the gap between frames when chip select rises. Each stimulus is followed by a settle margin before the next one, and each "no frame" claim is checked over a window longer than the full 200-cycle transfer.

// File: rtl/gain_wr_pkg.sv
package gain_wr_pkg;
  localparam int NPROF  = 4;
  localparam int PROF_W = $clog2(NPROF);
  localparam int GAIN_W = 8;
  localparam int ADDR_W = 3;

  typedef logic [PROF_W-1:0] prof_t;
  typedef logic [GAIN_W-1:0] gain_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_GAP} sh_state_e;

  // effective profile: pin i is paired with select bit i
  function automatic prof_t eff_profile(prof_t pins, prof_t sel);
    return pins | sel;
  endfunction

  // register address of a profile gain
  function automatic addr_t gain_addr(int prof, int base);
    return addr_t'(base + prof);
  endfunction
endpackage

// File: rtl/gain_pin_sync.sv
module gain_pin_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/gain_regfile.sv
module gain_regfile
  import gain_wr_pkg::*;
#(
  parameter int CTRL_ADDR = 0,
  parameter int GAIN_BASE = 1,
  parameter int SRST_BIT  = 5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  gain_t wr_data,
  input  prof_t act_prof,
  output prof_t sel_q,
  output gain_t act_gain,
  output logic  soft_rst
);
  logic             ctrl_hit;
  logic [NPROF-1:0] gain_hit;
  gain_t            gain_q [NPROF];

  assign ctrl_hit = wr_en && (wr_addr == addr_t'(CTRL_ADDR));
  assign soft_rst = ctrl_hit && wr_data[SRST_BIT];

  for (genvar p = 0; p < NPROF; p++) begin : g_hit
    assign gain_hit[p] = wr_en && (wr_addr == gain_addr(p, GAIN_BASE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int i = 0; i < NPROF; i++) gain_q[i] <= '0;
    end else if (soft_rst) begin
      sel_q <= '0;
      for (int i = 0; i < NPROF; i++) gain_q[i] <= '0;
    end else begin
      if (ctrl_hit) sel_q <= wr_data[PROF_W-1:0];
      for (int i = 0; i < NPROF; i++) begin
        if (gain_hit[i]) gain_q[i] <= wr_data;
      end
    end
  end

  assign act_gain = gain_q[act_prof];
endmodule

// File: rtl/gain_settle.sv
module gain_settle
  import gain_wr_pkg::*;
#(
  parameter int SETTLE_CYC = 56
) (
  input  logic  clk,
  input  logic  rst_n,
  input  gain_t act_gain,
  input  logic  busy,
  output logic  start,
  output gain_t cand_q,
  output gain_t shadow_q
);
  localparam int CW = $clog2(SETTLE_CYC);

  logic          settling_q;
  logic          force_q;
  logic [CW-1:0] cnt_q;
  logic          need;
  logic          same;

  function automatic logic window_done(logic [CW-1:0] c);
    return c == CW'(SETTLE_CYC - 1);
  endfunction

  assign need  = (act_gain != shadow_q) || force_q;
  assign same  = settling_q && (act_gain == cand_q);
  assign start = !busy && need && same && window_done(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settling_q <= 1'b0;
      force_q    <= 1'b1;
      cnt_q      <= '0;
      cand_q     <= '0;
      shadow_q   <= '0;
    end else if (busy) begin
      settling_q <= 1'b0;
      cnt_q      <= '0;
    end else if (!need) begin
      settling_q <= 1'b0;
      cnt_q      <= '0;
    end else if (!same) begin
      settling_q <= 1'b1;
      cand_q     <= act_gain;
      cnt_q      <= '0;
    end else if (start) begin
      settling_q <= 1'b0;
      shadow_q   <= cand_q;
      force_q    <= 1'b0;
      cnt_q      <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gain_shifter.sv
module gain_shifter
  import gain_wr_pkg::*;
#(
  parameter int CLK_DIV     = 8,
  parameter int GAP_PERIODS = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  gain_t load_val,
  output logic  busy,
  output logic  cs_n,
  output logic  sclk,
  output logic  sdata
);
  localparam int PH_W    = $clog2(CLK_DIV);
  localparam int BIT_W   = $clog2(GAIN_W);
  localparam int GAP_CYC = CLK_DIV * GAP_PERIODS;
  localparam int GAP_W   = $clog2(GAP_CYC);

  sh_state_e        state_q;
  logic [PH_W-1:0]  phase_q;
  logic [BIT_W-1:0] bit_q;
  logic [GAP_W-1:0] gap_q;
  gain_t            sreg_q;
  logic             bit_end;

  assign bit_end = (phase_q == PH_W'(CLK_DIV - 1));
  assign busy    = (state_q != SH_IDLE);
  assign cs_n    = (state_q != SH_SHIFT);
  assign sclk    = (state_q == SH_SHIFT) && (phase_q >= PH_W'(CLK_DIV / 2));
  assign sdata   = (state_q == SH_SHIFT) ? sreg_q[GAIN_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      phase_q <= '0;
      bit_q   <= '0;
      gap_q   <= '0;
      sreg_q  <= '0;
    end else begin
      case (state_q)
        SH_IDLE: begin
          if (start) begin
            state_q <= SH_SHIFT;
            sreg_q  <= load_val;
            phase_q <= '0;
            bit_q   <= '0;
          end
        end
        SH_SHIFT: begin
          phase_q <= phase_q + 1'b1;
          if (bit_end) begin
            phase_q <= '0;
            if (bit_q == BIT_W'(GAIN_W - 1)) begin
              state_q <= SH_GAP;
              gap_q   <= '0;
            end else begin
              bit_q  <= bit_q + 1'b1;
              sreg_q <= {sreg_q[GAIN_W-2:0], 1'b0};
            end
          end
        end
        SH_GAP: begin
          gap_q <= gap_q + 1'b1;
          if (gap_q == GAP_W'(GAP_CYC - 1)) state_q <= SH_IDLE;
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gain_serial_writer.sv
module gain_serial_writer
  import gain_wr_pkg::*;
#(
  parameter int SETTLE_CYC  = 56,
  parameter int CLK_DIV     = 8,
  parameter int GAP_PERIODS = 2,
  parameter int CTRL_ADDR   = 0,
  parameter int GAIN_BASE   = 1,
  parameter int SRST_BIT    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [GAIN_W-1:0] wr_data,
  input  logic [PROF_W-1:0] prof_pin,
  output logic              amp_cs_n,
  output logic              amp_sclk,
  output logic              amp_sdata
);
  prof_t pins_sync;
  prof_t sel_bits;
  prof_t act_prof;
  gain_t eff_gain;
  gain_t frame_val;
  gain_t shadow_val;
  logic  frame_start;
  logic  sh_busy;
  logic  soft_rst;

  gain_pin_sync #(.W(PROF_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(prof_pin), .sync_out(pins_sync)
  );

  assign act_prof = eff_profile(pins_sync, sel_bits);

  gain_regfile #(
    .CTRL_ADDR(CTRL_ADDR), .GAIN_BASE(GAIN_BASE), .SRST_BIT(SRST_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .act_prof(act_prof), .sel_q(sel_bits),
    .act_gain(eff_gain), .soft_rst(soft_rst)
  );

  gain_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .act_gain(eff_gain), .busy(sh_busy),
    .start(frame_start), .cand_q(frame_val), .shadow_q(shadow_val)
  );

  gain_shifter #(.CLK_DIV(CLK_DIV), .GAP_PERIODS(GAP_PERIODS)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(frame_start), .load_val(frame_val),
    .busy(sh_busy), .cs_n(amp_cs_n), .sclk(amp_sclk), .sdata(amp_sdata)
  );
endmodule

// File: rtl/gain_writer_chk.sv
module gain_writer_chk
  import gain_wr_pkg::*;
#(
  parameter int CLK_DIV     = 8,
  parameter int GAP_PERIODS = 2,
  parameter int CTRL_ADDR   = 0,
  parameter int SRST_BIT    = 5
) (
  input logic  clk,
  input logic  rst_n,
  input logic  wr_en,
  input addr_t wr_addr,
  input gain_t wr_data,
  input logic  amp_cs_n,
  input logic  amp_sclk,
  input logic  amp_sdata,
  input gain_t eff_gain,
  input logic  frame_start,
  input prof_t sel_bits
);
  localparam int FRAME_CYC = GAIN_W * CLK_DIV;
  localparam int GAP_CYC   = CLK_DIV * GAP_PERIODS;

  logic [7:0] low_cnt, high_cnt, stable_cnt;
  gain_t      eff_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt    <= '0;
      high_cnt   <= '0;
      stable_cnt <= '0;
      eff_prev   <= '0;
    end else begin
      eff_prev   <= eff_gain;
      low_cnt    <= amp_cs_n ? 8'd0 : (low_cnt == 8'hff ? low_cnt : low_cnt + 8'd1);
      high_cnt   <= !amp_cs_n ? 8'd0 : (high_cnt == 8'hff ? high_cnt : high_cnt + 8'd1);
      stable_cnt <= (eff_gain != eff_prev) ? 8'd0 :
                    (stable_cnt == 8'hff ? stable_cnt : stable_cnt + 8'd1);
    end
  end

  // R7: a frame starts only after the gain has been steady long enough
  p_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (stable_cnt >= 8'd47));

  // R8: serial clock parked low while deselected
  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    amp_cs_n |-> !amp_sclk);

  // R8: data holds while the serial clock is high
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!amp_cs_n && !$past(amp_cs_n) && amp_sclk) |-> $stable(amp_sdata));

  // R9: every frame runs its full length
  p_frame_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(amp_cs_n) |-> (low_cnt == 8'(FRAME_CYC)));

  // R10: minimum deselect time between frames
  p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(amp_cs_n) |-> (high_cnt >= 8'(GAP_CYC)));

  // R4: software reset leaves the select bits cleared
  p_sel_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == addr_t'(CTRL_ADDR) && wr_data[SRST_BIT]) |=> (sel_bits == '0));
endmodule

bind gain_serial_writer gain_writer_chk #(
  .CLK_DIV(CLK_DIV), .GAP_PERIODS(GAP_PERIODS),
  .CTRL_ADDR(CTRL_ADDR), .SRST_BIT(SRST_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .amp_cs_n(amp_cs_n), .amp_sclk(amp_sclk), .amp_sdata(amp_sdata),
  .eff_gain(eff_gain), .frame_start(frame_start), .sel_bits(sel_bits)
);

// File: tb/tb_gain_serial_writer.sv
module tb_gain_serial_writer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] prof_pin = '0;
  logic       amp_cs_n, amp_sclk, amp_sdata;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  gain_serial_writer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prof_pin(prof_pin), .amp_cs_n(amp_cs_n), .amp_sclk(amp_sclk), .amp_sdata(amp_sdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // frame monitor, sampled on the falling clock edge
  int         fall_cnt = 0, frame_cnt = 0, nbits = 0, high_run = 0;
  int         falls [32];
  int         rises [32];
  logic [7:0] vals  [32];
  logic [7:0] shreg = '0;
  logic       prev_cs = 1'b1, prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !amp_cs_n) begin
        if (fall_cnt > 0) chk(high_run >= 16, "R10 gap", high_run, 16);
        if (fall_cnt < 32) falls[fall_cnt] = cyc;
        fall_cnt++;
        nbits = 0;
        shreg = '0;
      end
      if (!amp_cs_n && amp_sclk && !prev_sclk) begin
        shreg = {shreg[6:0], amp_sdata};
        nbits++;
      end
      if (!prev_cs && amp_cs_n) begin
        chk(nbits == 8, "R8 bit count", nbits, 8);
        if (frame_cnt < 32) begin
          vals[frame_cnt]  = shreg;
          rises[frame_cnt] = cyc;
        end
        frame_cnt++;
        high_run = 0;
      end
      if (amp_cs_n) high_run++;
      prev_cs   = amp_cs_n;
      prev_sclk = amp_sclk;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d, output int mark);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    mark = cyc;
  endtask

  task automatic set_pins(input logic [1:0] p, output int mark);
    @(negedge clk);
    prof_pin = p;
    mark = cyc;
  endtask

  // waits for frame number idx and checks value, latency and total time
  task automatic expect_frame(input int idx, input logic [7:0] exp, input int mark, input string req);
    for (int i = 0; i < 400 && frame_cnt <= idx; i++) @(negedge clk);
    chk(frame_cnt > idx, {req, " frame sent"}, frame_cnt, idx + 1);
    if (frame_cnt > idx) begin
      chk(vals[idx] == exp, {req, " frame value"}, vals[idx], exp);
      if (mark >= 0) begin
        chk((falls[idx] - mark >= 48) && (falls[idx] - mark <= 64),
            "R7 settle latency", falls[idx] - mark, 57);
        chk(rises[idx] - mark <= 200, "R10 transfer time", rises[idx] - mark, 200);
      end
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic expect_quiet(input int ncyc, input string req);
    int base = fall_cnt;
    repeat (ncyc) @(negedge clk);
    chk(fall_cnt == base, {req, " no frame"}, fall_cnt - base, 0);
  endtask

  task automatic t_reset();
    int m;
    repeat (5) @(negedge clk);
    chk(amp_cs_n == 1'b1, "R3 cs_n at reset", amp_cs_n, 1);
    chk(amp_sclk == 1'b0, "R3 sclk at reset", amp_sclk, 0);
    rst_n = 1'b1;
    m = cyc;
    expect_frame(0, 8'h00, m, "R3");
  endtask

  task automatic t_active_write();
    int m;
    wr(3'd1, 8'hA5, m);
    expect_frame(frame_cnt, 8'hA5, m, "R6 R1");
  endtask

  task automatic t_ignored_writes();
    int m;
    wr(3'd3, 8'h3C, m);
    expect_quiet(250, "R6 inactive write");
    wr(3'd1, 8'hA5, m);
    expect_quiet(250, "R6 same value");
    wr(3'd6, 8'hFF, m);
    expect_quiet(250, "R1 unmapped address");
  endtask

  task automatic t_pin_profile();
    int m;
    set_pins(2'b10, m);
    expect_frame(frame_cnt, 8'h3C, m, "R2 pins");
  endtask

  task automatic t_same_gain_profile();
    int m;
    wr(3'd4, 8'h3C, m);
    expect_quiet(250, "R6 inactive p3");
    wr(3'd0, 8'h01, m);
    expect_quiet(250, "R5 profile change same gain");
  endtask

  task automatic t_or_profile();
    int m;
    set_pins(2'b00, m);
    expect_frame(frame_cnt, 8'h00, m, "R2 select bits");
  endtask

  task automatic t_restart();
    int m, idx;
    idx = frame_cnt;
    wr(3'd2, 8'h11, m);
    repeat (20) @(negedge clk);
    wr(3'd2, 8'h22, m);
    expect_frame(idx, 8'h22, m, "R7 restart");
    expect_quiet(250, "R7 single frame");
  endtask

  task automatic t_inflight();
    int m, m2, idx;
    idx = frame_cnt;
    wr(3'd2, 8'h5A, m);
    for (int i = 0; i < 200 && fall_cnt <= idx; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    wr(3'd2, 8'h77, m2);
    expect_frame(idx, 8'h5A, m, "R9 first");
    expect_frame(idx + 1, 8'h77, -1, "R9 newest");
  endtask

  task automatic t_soft_nonzero();
    int m;
    wr(3'd0, 8'h23, m);
    expect_frame(frame_cnt, 8'h00, m, "R4 soft reset nonzero");
    wr(3'd2, 8'h66, m);
    expect_quiet(250, "R4 select bits cleared");
    wr(3'd1, 8'h44, m);
    expect_frame(frame_cnt, 8'h44, m, "R4 profile 0 active");
  endtask

  task automatic t_soft_zero();
    int m;
    wr(3'd3, 8'h3C, m);
    wr(3'd1, 8'h00, m);
    expect_frame(frame_cnt, 8'h00, m, "R4 zero gain");
    wr(3'd0, 8'h20, m);
    expect_quiet(250, "R4 soft reset zero");
    set_pins(2'b10, m);
    expect_quiet(250, "R4 gains cleared");
  endtask

  initial begin
    t_reset();
    t_active_write();
    t_ignored_writes();
    t_pin_profile();
    t_same_gain_profile();
    t_or_profile();
    t_restart();
    t_inflight();
    t_soft_nonzero();
    t_soft_zero();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule